// File: doc/BRIEF.md
# Privilege-Filtered Performance Counter Bank

This block holds a set of profiling counters for a processor core: up to thirty-one programmable event counters and one cycle counter. Every clock the core presents a vector of single-cycle event pulses, the privilege level it is running at (0 to 3), a flag saying whether it is in the non-secure state, and a flag saying that event counting is prohibited in the current region. A counter advances by one only when all of these hold: the global run bit is set, its bit in the enable mask is set, the region rules allow it, and its own filter word permits the present level and security state. For an event counter, the event its filter selects must also pulse in that cycle.

Software sees the counters, the filter words, the enable mask and the control word through a flat register port. A write lands on the next rising edge. The read data follows the address combinationally. Each filter word packs the selected event number into its low half. Its top byte holds five privilege bits that are read in pairs, so a level is allowed when the right bits match or differ. The cycle counter has a filter word of its own with the same layout, and it counts clocks instead of events.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, every filter word, the enable mask and the control word read as zero.
- R2: Register map (7-bit address): event counter n at n (0 to 30), cycle counter at 31, filter of event counter n at 32+n, cycle filter at 63, enable mask at 64, control word at 65. Any other address reads zero. Read data follows the address in the same cycle, and a write takes effect at the next rising edge. Filter, mask and control take the low 32 data bits. An event counter keeps the low EVT_CNT_W bits.
- R3: While control bit 0 is 0, no counter advances, whatever the mask, the filters or the inputs are.
- R4: Enable mask bit n (n = 0 to 30) gates event counter n, and mask bit 31 gates the cycle counter. A counter whose bit is 0 never advances.
- R5: Filter bits [15:0] give an event number. An event counter advances only in a cycle where the pulse input at that index is 1. A number at or above NUM_EVENTS never counts.
- R6: At privilege level 0 the filter's privilege bits have no effect, and counting is permitted.
- R7: At level 1, filter bit 31 must be 0. In the non-secure state, bit 29 must also equal bit 31.
- R8: At level 2, filter bit 27 must be 1. In the secure state, bit 24 must also differ from bit 27.
- R9: At level 3, counting is permitted exactly when filter bit 26 equals bit 31, whatever the security flag is.
- R10: While the prohibit input is 1, no event counter advances. The cycle counter is stopped too if control bit 5 is 1, and it keeps counting if that bit is 0.
- R11: The cycle counter ignores the event pulses. It advances by one on each clock that its own filter (address 63), mask bit 31, the global run bit and the prohibit rule all permit.
- R12: Counters wrap to zero: an event counter after all-ones of EVT_CNT_W bits, and the cycle counter after all-ones of 64 bits.
- R13: A register write to a counter in a cycle where that counter would advance loads the written value, and that cycle's increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_EVENTS | One bit per event number, high in a cycle where that event occurs |
| priv_lvl | input | 2 | Current privilege level, 0 to 3 |
| nonsecure | input | 1 | 1 when the core is in the non-secure state |
| prohibit | input | 1 | 1 while event counting is prohibited in the current region |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address (map in R2) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr, zero-extended |

## Verification
The main sweep runs all 32 settings of the five privilege bits against all four levels and both security states, which is 256 cases. In each case the bench counts a fixed window on event counter 0 and on the cycle counter. The cycle filter always gets a bit pattern different from the event filter's, so a design that uses the wrong filter word for either counter gives the wrong count. The event number moves with each case, so a counter that looks at a fixed pulse bit also shows up. Directed windows then cover the remaining rules. Switching off the global run bit, and then clearing single mask bits, shows which gate each counter obeys. Raising prohibit with control bit 5 at 0 and then at 1 shows whether the cycle counter is treated differently from the event counters. A pulse vector with one matching bit, one lone bit and one aliasing bit shows whether the event number is decoded in full. Loading all-ones and then counting one step shows wrap-around. A counter write landing in a counting cycle shows which of the two wins.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

   localparam int DATA_W   = 64;
   localparam int ADDR_W   = 7;
   localparam int FILT_W   = 32;
   localparam int EVNUM_W  = 16;
   localparam int SLOTS    = 32;
   localparam int CYC_SLOT = SLOTS - 1;

   // privilege bit positions inside a filter word
   localparam int FB_L1_BLOCK = 31;
   localparam int FB_NS_L1    = 29;
   localparam int FB_L2_ALLOW = 27;
   localparam int FB_L3_SEL   = 26;
   localparam int FB_S_L2     = 24;

   // control word bits
   localparam int CTRL_RUN      = 0;
   localparam int CTRL_CYC_HALT = 5;

   localparam logic [ADDR_W-1:0] ADDR_MASK = 7'h40;
   localparam logic [ADDR_W-1:0] ADDR_CTRL = 7'h41;

   typedef struct packed {
      logic l1_block;
      logic ns_l1;
      logic l2_allow;
      logic l3_sel;
      logic s_l2;
   } priv_bits_t;

   typedef struct packed {
      logic       is_cnt;
      logic       is_filt;
      logic       is_mask;
      logic       is_ctrl;
      logic [4:0] slot;
   } reg_sel_t;

   function automatic priv_bits_t get_priv_bits(input logic [FILT_W-1:0] f);
      priv_bits_t b;
      b.l1_block = f[FB_L1_BLOCK];
      b.ns_l1    = f[FB_NS_L1];
      b.l2_allow = f[FB_L2_ALLOW];
      b.l3_sel   = f[FB_L3_SEL];
      b.s_l2     = f[FB_S_L2];
      return b;
   endfunction

   function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
      reg_sel_t s;
      s.is_cnt  = (a[6:5] == 2'b00);
      s.is_filt = (a[6:5] == 2'b01);
      s.is_mask = (a == ADDR_MASK);
      s.is_ctrl = (a == ADDR_CTRL);
      s.slot    = a[4:0];
      return s;
   endfunction

endpackage

// File: rtl/pcb_event_pick.sv
module pcb_event_pick #(
   parameter int NUM_EVENTS = 64
) (
   input  logic [NUM_EVENTS-1:0]     evt_pulse,
   input  logic [pcb_pkg::EVNUM_W-1:0] evt_num,
   output logic                      hit
);
   localparam int IDX_W = (NUM_EVENTS > 1) ? $clog2(NUM_EVENTS) : 1;
   localparam logic [pcb_pkg::EVNUM_W:0] LIMIT = (pcb_pkg::EVNUM_W+1)'(NUM_EVENTS);

   logic             in_range;
   logic [IDX_W-1:0] idx;

   assign in_range = ({1'b0, evt_num} < LIMIT);

   generate
      if (NUM_EVENTS > 1) begin : g_multi
         assign idx = evt_num[IDX_W-1:0];
      end else begin : g_single
         assign idx = 1'b0;
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      if (in_range) hit = evt_pulse[idx];
   end
endmodule

// File: rtl/pcb_priv_filter.sv
module pcb_priv_filter (
   input  pcb_pkg::priv_bits_t bits,
   input  logic [1:0]          priv_lvl,
   input  logic                nonsecure,
   output logic                allow
);
   always_comb begin
      unique case (priv_lvl)
         2'd0: allow = 1'b1;
         2'd1: allow = !bits.l1_block &&
                       (!nonsecure || (bits.ns_l1 == bits.l1_block));
         2'd2: allow = bits.l2_allow &&
                       (nonsecure || (bits.s_l2 != bits.l2_allow));
         default: allow = (bits.l3_sel == bits.l1_block);
      endcase
   end
endmodule

// File: rtl/pcb_count_reg.sv
module pcb_count_reg #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= load_val;
      else if (step) q <= q + W'(1);
   end
endmodule

// File: rtl/pcb_counter_slice.sv
module pcb_counter_slice #(
   parameter int CNT_W = 32
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  priv_lvl,
   input  logic                        nonsecure,
   input  logic                        glob_run,
   input  logic                        mask_en,
   input  logic                        region_ok,
   input  logic                        src_hit,
   input  logic                        cnt_wr,
   input  logic [CNT_W-1:0]            cnt_wdata,
   input  logic                        filt_wr,
   input  logic [pcb_pkg::FILT_W-1:0]  filt_wdata,
   output logic [CNT_W-1:0]            cnt_q,
   output logic [pcb_pkg::FILT_W-1:0]  filt_q
);
   logic priv_ok;
   logic step;

   always_ff @(posedge clk) begin
      if (!rst_n)       filt_q <= '0;
      else if (filt_wr) filt_q <= filt_wdata;
   end

   pcb_priv_filter u_filt (
      .bits      (pcb_pkg::get_priv_bits(filt_q)),
      .priv_lvl  (priv_lvl),
      .nonsecure (nonsecure),
      .allow     (priv_ok)
   );

   assign step = glob_run && mask_en && region_ok && src_hit && priv_ok;

   pcb_count_reg #(.W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cnt_wr),
      .load_val (cnt_wdata),
      .step     (step),
      .q        (cnt_q)
   );
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
   import pcb_pkg::*;
#(
   parameter int NUM_EVT_CNT = 31,
   parameter int EVT_CNT_W   = 32,
   parameter int CYC_CNT_W   = 64,
   parameter int NUM_EVENTS  = 64
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] evt_pulse,
   input  logic [1:0]            priv_lvl,
   input  logic                  nonsecure,
   input  logic                  prohibit,
   input  logic                  reg_wr,
   input  logic [6:0]            reg_addr,
   input  logic [63:0]           reg_wdata,
   output logic [63:0]           reg_rdata
);
   // elaboration-time parameter checks
   generate
      if (NUM_EVT_CNT < 1 || NUM_EVT_CNT > SLOTS - 1) begin : g_bad_count
         $error("NUM_EVT_CNT must lie in 1..31");
      end
      if (EVT_CNT_W != 32 && EVT_CNT_W != 64) begin : g_bad_evt_w
         $error("EVT_CNT_W must be 32 or 64");
      end
      if (CYC_CNT_W != DATA_W) begin : g_bad_cyc_w
         $error("CYC_CNT_W must equal the 64-bit data path");
      end
      if (NUM_EVENTS < 1 || NUM_EVENTS > (1 << EVNUM_W)) begin : g_bad_events
         $error("NUM_EVENTS must lie in 1..65536");
      end
   endgenerate

   localparam int MASK_W = SLOTS;

   reg_sel_t sel;
   assign sel = decode_addr(reg_addr);

   logic [FILT_W-1:0] ctrl_q;
   logic [MASK_W-1:0] mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else if (reg_wr) begin
         if (sel.is_ctrl) ctrl_q <= reg_wdata[FILT_W-1:0];
         if (sel.is_mask) mask_q <= reg_wdata[MASK_W-1:0];
      end
   end

   logic glob_run;
   logic evt_region_ok;
   logic cyc_region_ok;

   assign glob_run      = ctrl_q[CTRL_RUN];
   assign evt_region_ok = !prohibit;
   assign cyc_region_ok = !(prohibit && ctrl_q[CTRL_CYC_HALT]);

   logic [NUM_EVT_CNT-1:0][EVT_CNT_W-1:0] evt_cnt;
   logic [NUM_EVT_CNT-1:0][FILT_W-1:0]    evt_filt;
   logic [NUM_EVT_CNT-1:0]                evt_hit;
   logic [CYC_CNT_W-1:0]                  cyc_cnt;
   logic [FILT_W-1:0]                     cyc_filt;

   generate
      for (genvar i = 0; i < NUM_EVT_CNT; i++) begin : g_evt
         logic wr_cnt;
         logic wr_filt;
         assign wr_cnt  = reg_wr && sel.is_cnt  && (sel.slot == 5'(i));
         assign wr_filt = reg_wr && sel.is_filt && (sel.slot == 5'(i));

         pcb_event_pick #(.NUM_EVENTS(NUM_EVENTS)) u_pick (
            .evt_pulse (evt_pulse),
            .evt_num   (evt_filt[i][EVNUM_W-1:0]),
            .hit       (evt_hit[i])
         );

         pcb_counter_slice #(.CNT_W(EVT_CNT_W)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .priv_lvl   (priv_lvl),
            .nonsecure  (nonsecure),
            .glob_run   (glob_run),
            .mask_en    (mask_q[i]),
            .region_ok  (evt_region_ok),
            .src_hit    (evt_hit[i]),
            .cnt_wr     (wr_cnt),
            .cnt_wdata  (reg_wdata[EVT_CNT_W-1:0]),
            .filt_wr    (wr_filt),
            .filt_wdata (reg_wdata[FILT_W-1:0]),
            .cnt_q      (evt_cnt[i]),
            .filt_q     (evt_filt[i])
         );
      end
   endgenerate

   logic cyc_wr_cnt;
   logic cyc_wr_filt;
   assign cyc_wr_cnt  = reg_wr && sel.is_cnt  && (sel.slot == 5'(CYC_SLOT));
   assign cyc_wr_filt = reg_wr && sel.is_filt && (sel.slot == 5'(CYC_SLOT));

   pcb_counter_slice #(.CNT_W(CYC_CNT_W)) u_cyc (
      .clk        (clk),
      .rst_n      (rst_n),
      .priv_lvl   (priv_lvl),
      .nonsecure  (nonsecure),
      .glob_run   (glob_run),
      .mask_en    (mask_q[CYC_SLOT]),
      .region_ok  (cyc_region_ok),
      .src_hit    (1'b1),
      .cnt_wr     (cyc_wr_cnt),
      .cnt_wdata  (reg_wdata[CYC_CNT_W-1:0]),
      .filt_wr    (cyc_wr_filt),
      .filt_wdata (reg_wdata[FILT_W-1:0]),
      .cnt_q      (cyc_cnt),
      .filt_q     (cyc_filt)
   );

   // read path
   always_comb begin
      reg_rdata = '0;
      if (sel.is_cnt) begin
         if (sel.slot == 5'(CYC_SLOT)) reg_rdata = DATA_W'(cyc_cnt);
         for (int k = 0; k < NUM_EVT_CNT; k++) begin
            if (sel.slot == 5'(k)) reg_rdata = DATA_W'(evt_cnt[k]);
         end
      end else if (sel.is_filt) begin
         if (sel.slot == 5'(CYC_SLOT)) reg_rdata = DATA_W'(cyc_filt);
         for (int k = 0; k < NUM_EVT_CNT; k++) begin
            if (sel.slot == 5'(k)) reg_rdata = DATA_W'(evt_filt[k]);
         end
      end else if (sel.is_mask) begin
         reg_rdata = DATA_W'(mask_q);
      end else if (sel.is_ctrl) begin
         reg_rdata = DATA_W'(ctrl_q);
      end
   end
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
   parameter int NUM_EVT_CNT = 31,
   parameter int EVT_CNT_W   = 32,
   parameter int CYC_CNT_W   = 64
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  reg_wr,
   input logic [6:0]                            reg_addr,
   input logic [63:0]                           reg_wdata,
   input logic                                  prohibit,
   input logic [1:0]                            priv_lvl,
   input logic                                  ctrl_run,
   input logic                                  ctrl_halt,
   input logic                                  cyc_mask,
   input logic                                  cyc_l2_allow,
   input logic [CYC_CNT_W-1:0]                  cyc_cnt,
   input logic [NUM_EVT_CNT-1:0][EVT_CNT_W-1:0] evt_cnt
);
   assert_run_off_cyc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_run && !reg_wr) |=> $stable(cyc_cnt));

   assert_run_off_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_run && !reg_wr) |=> $stable(evt_cnt));

   assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_mask && !reg_wr) |=> $stable(cyc_cnt));

   assert_l2_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (priv_lvl == 2'd2 && !cyc_l2_allow && !reg_wr) |=> $stable(cyc_cnt));

   assert_prohibit_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (prohibit && !reg_wr) |=> $stable(evt_cnt));

   assert_prohibit_cyc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (prohibit && ctrl_halt && !reg_wr) |=> $stable(cyc_cnt));

   assert_single_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> (cyc_cnt == $past(cyc_cnt)) ||
                  (cyc_cnt == $past(cyc_cnt) + CYC_CNT_W'(1)));

   assert_write_wins_cyc_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 7'h1F) |=> cyc_cnt == $past(reg_wdata[CYC_CNT_W-1:0]));

   assert_write_wins_evt_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 7'h00) |=> evt_cnt[0] == $past(reg_wdata[EVT_CNT_W-1:0]));
endmodule

bind perf_counter_bank pcb_checker #(
   .NUM_EVT_CNT (NUM_EVT_CNT),
   .EVT_CNT_W   (EVT_CNT_W),
   .CYC_CNT_W   (CYC_CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_wr       (reg_wr),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .prohibit     (prohibit),
   .priv_lvl     (priv_lvl),
   .ctrl_run     (ctrl_q[0]),
   .ctrl_halt    (ctrl_q[5]),
   .cyc_mask     (mask_q[31]),
   .cyc_l2_allow (cyc_filt[27]),
   .cyc_cnt      (cyc_cnt),
   .evt_cnt      (evt_cnt)
);

// File: tb/perf_counter_bank_tb_top.sv
module perf_counter_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NEV        = 64;
   localparam int WIN        = 5;
   localparam int WATCHDOG   = 150000;

   localparam logic [6:0] A_CNT0  = 7'h00;
   localparam logic [6:0] A_CYC   = 7'h1F;
   localparam logic [6:0] A_FILT0 = 7'h20;
   localparam logic [6:0] A_CFILT = 7'h3F;
   localparam logic [6:0] A_MASK  = 7'h40;
   localparam logic [6:0] A_CTRL  = 7'h41;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NEV-1:0]  evt_pulse = '0;
   logic [1:0]      priv_lvl = 2'd0;
   logic            nonsecure = 1'b0;
   logic            prohibit = 1'b0;
   logic            reg_wr = 1'b0;
   logic [6:0]      reg_addr = '0;
   logic [63:0]     reg_wdata = '0;
   logic [63:0]     reg_rdata;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   perf_counter_bank #(.NUM_EVENTS(NEV)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_pulse (evt_pulse),
      .priv_lvl  (priv_lvl),
      .nonsecure (nonsecure),
      .prohibit  (prohibit),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input logic [6:0] a, input logic [63:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(input logic [6:0] a, output logic [63:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic check(input string req, input logic [6:0] a, input logic [63:0] exp);
      logic [63:0] got;
      rd(a, got);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s addr=%h actual=%h expected=%h", req, a, got, exp);
      end
   endtask

   // privilege bits b[4:0] -> filter bits 31,29,27,26,24
   function automatic logic [31:0] mk_filt(input logic [4:0] b, input logic [15:0] ev);
      return {b[4], 1'b0, b[3], 1'b0, b[2], b[1], 1'b0, b[0], 8'h00, ev};
   endfunction

   function automatic bit permitted(input logic [31:0] f, input int lvl, input bit ns);
      case (lvl)
         0: return 1'b1;
         1: return !f[31] && (!ns || (f[29] == f[31]));
         2: return f[27] && (ns || (f[24] != f[27]));
         default: return f[26] == f[31];
      endcase
   endfunction

   task automatic zero_pair();
      wr(A_CNT0, 64'd0);
      wr(A_CYC, 64'd0);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check("R1", A_CNT0, 64'd0);
      check("R1", A_CYC, 64'd0);
      check("R1", A_FILT0, 64'd0);
      check("R1", A_CFILT, 64'd0);
      check("R1", A_MASK, 64'd0);
      check("R1", A_CTRL, 64'd0);

      // R2: map, readback, truncation, unmapped
      wr(A_FILT0 + 7'd3, 64'hFFFF_FFFF_DEAD_BEEF);
      check("R2", A_FILT0 + 7'd3, 64'h0000_0000_DEAD_BEEF);
      wr(A_CNT0, 64'h0000_0001_0000_0005);
      check("R2", A_CNT0, 64'd5);
      check("R2", 7'h50, 64'd0);
      wr(A_FILT0 + 7'd3, 64'd0);

      wr(A_MASK, 64'hFFFF_FFFF);

      // R6..R9 with R11: sweep privilege bits x level x security
      for (int cfg = 0; cfg < 32; cfg++) begin
         for (int lvl = 0; lvl < 4; lvl++) begin
            for (int ns = 0; ns < 2; ns++) begin
               logic [31:0] f;
               logic [31:0] cf;
               logic [15:0] ev;
               ev = 16'((cfg * 5 + lvl * 3 + ns) % NEV);
               f  = mk_filt(5'(cfg), ev);
               cf = mk_filt(5'(cfg) ^ 5'h15, 16'hABCD);
               priv_lvl  = 2'(lvl);
               nonsecure = ns[0];
               evt_pulse = NEV'(1) << ev;
               wr(A_CTRL, 64'd0);
               wr(A_FILT0, 64'(f));
               wr(A_CFILT, 64'(cf));
               zero_pair();
               wr(A_CTRL, 64'd1);
               idle(WIN);
               case (lvl)
                  0: begin check("R6 evt", A_CNT0, permitted(f, lvl, ns[0]) ? 64'(WIN) : 64'd0);
                           check("R6 R11 cyc", A_CYC, permitted(cf, lvl, ns[0]) ? 64'(WIN) : 64'd0); end
                  1: begin check("R7 evt", A_CNT0, permitted(f, lvl, ns[0]) ? 64'(WIN) : 64'd0);
                           check("R7 R11 cyc", A_CYC, permitted(cf, lvl, ns[0]) ? 64'(WIN) : 64'd0); end
                  2: begin check("R8 evt", A_CNT0, permitted(f, lvl, ns[0]) ? 64'(WIN) : 64'd0);
                           check("R8 R11 cyc", A_CYC, permitted(cf, lvl, ns[0]) ? 64'(WIN) : 64'd0); end
                  default: begin check("R9 evt", A_CNT0, permitted(f, lvl, ns[0]) ? 64'(WIN) : 64'd0);
                           check("R9 R11 cyc", A_CYC, permitted(cf, lvl, ns[0]) ? 64'(WIN) : 64'd0); end
               endcase
            end
         end
      end

      // common open setting for directed tests
      priv_lvl = 2'd0; nonsecure = 1'b0;
      wr(A_CTRL, 64'd0);
      wr(A_FILT0, 64'd0);
      wr(A_CFILT, 64'd0);
      evt_pulse = NEV'(1);

      // R3: global run bit off
      zero_pair();
      idle(WIN);
      check("R3 evt", A_CNT0, 64'd0);
      check("R3 cyc", A_CYC, 64'd0);

      // R4: mask gates each counter
      wr(A_MASK, 64'h0000_0001);
      zero_pair();
      wr(A_CTRL, 64'd1);
      idle(WIN);
      check("R4 evt on", A_CNT0, 64'(WIN));
      check("R4 cyc off", A_CYC, 64'd0);
      wr(A_CTRL, 64'd0);
      wr(A_MASK, 64'h8000_0000);
      zero_pair();
      wr(A_CTRL, 64'd1);
      idle(WIN);
      check("R4 evt off", A_CNT0, 64'd0);
      check("R4 cyc on", A_CYC, 64'(WIN));
      wr(A_CTRL, 64'd0);
      wr(A_MASK, 64'hFFFF_FFFF);

      // R5: event selection on several counters
      wr(A_FILT0 + 7'd5,  64'd3);
      wr(A_FILT0 + 7'd6,  64'd4);
      wr(A_FILT0 + 7'd7,  64'd70);
      wr(A_FILT0 + 7'd8,  64'd67);
      wr(A_FILT0 + 7'd30, 64'd63);
      for (int k = 5; k <= 8; k++) wr(A_CNT0 + 7'(k), 64'd0);
      wr(A_CNT0 + 7'd30, 64'd0);
      evt_pulse = (NEV'(1) << 3) | (NEV'(1) << 6) | (NEV'(1) << 63);
      wr(A_CTRL, 64'd1);
      idle(WIN);
      check("R5 match", A_CNT0 + 7'd5, 64'(WIN));
      check("R5 idle event", A_CNT0 + 7'd6, 64'd0);
      check("R5 out of range 70", A_CNT0 + 7'd7, 64'd0);
      check("R5 out of range 67", A_CNT0 + 7'd8, 64'd0);
      check("R5 top event", A_CNT0 + 7'd30, 64'(WIN));
      wr(A_CTRL, 64'd0);
      evt_pulse = NEV'(1);

      // R10: prohibited region
      prohibit = 1'b1;
      zero_pair();
      wr(A_CTRL, 64'h01);
      idle(WIN);
      check("R10 evt stops", A_CNT0, 64'd0);
      check("R10 cyc runs", A_CYC, 64'(WIN));
      wr(A_CTRL, 64'd0);
      zero_pair();
      wr(A_CTRL, 64'h21);
      idle(WIN);
      check("R10 cyc halts", A_CYC, 64'd0);
      check("R10 evt stops", A_CNT0, 64'd0);
      prohibit = 1'b0;
      wr(A_CTRL, 64'd0);

      // R12: wrap-around
      wr(A_CNT0, 64'h0000_0000_FFFF_FFFF);
      wr(A_CYC, 64'hFFFF_FFFF_FFFF_FFFF);
      wr(A_CTRL, 64'd1);
      idle(1);
      check("R12 evt wrap", A_CNT0, 64'd0);
      check("R12 cyc wrap", A_CYC, 64'd0);

      // R13: write beats increment (counting is live)
      wr(A_CNT0, 64'd100);
      check("R13 evt load", A_CNT0, 64'd100);
      idle(1);
      check("R13 evt resumes", A_CNT0, 64'd101);
      wr(A_CYC, 64'd500);
      check("R13 cyc load", A_CYC, 64'd500);
      wr(A_CTRL, 64'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule